// File: doc/BRIEF.md
# Banked Configuration Register Window

This block exposes fourteen per-channel configuration registers to a host through only two ports. One is a byte-wide pointer and the other is a word-wide data port. The pointer byte selects the channel and a register index from 0 to 7. It also carries three global bus options: target response speed, master burst disable and a posted-write wait state. A further pointer bit makes the index step forward after every data-port access.

Software writes the pointer once. It then streams a whole bank through the data port, reading or writing. The index wraps from 6 back to 0. Register outputs go straight to the per-channel timing generator, the DMA enable logic and the read-ahead engine.

The registers differ in behaviour. The two base-address registers are full words. The general-config and timing registers are bytes. The read-ahead count and read-ahead control registers are write-only. The FIFO-clear bit is a command that lasts one clock.

The host side uses plain single-cycle strobes. A strobe is accepted in the cycle it is high, and the port never stalls the host. Read data is combinational from the current pointer. A read strobe therefore marks the end of the read access and may advance the index.

Top module: `cfg_window`

## Requirements
- R1: After reset the pointer reads 0x50. Global outputs are `devsel_medium`=1, `burst_en`=1 and `posted_wait`=1.
- R2: A pointer write stores all eight bits. In the pointer byte, bit 3 selects channel 1, bit 4 drives `devsel_medium`, bit 6 drives `posted_wait`, and `burst_en` is the inverse of bit 5. Bit 5 is write-only and always reads 0.
- R3: Reset defaults per channel (channel 0 / channel 1) are as follows. Index 0 (command base) is 0x01F0/0x0170. Index 1 (general config) is 0x0001 on both. Index 4 (control base) is 0x03F6/0x0376. Index 5 (data timing) is 0x00F5 and index 6 (command timing) is 0x00DE.
- R4: A data write reaches only the register at the pointer's index in the channel the pointer selects; the other channel's bank is unchanged. In general config, bit 7 drives `dma_en`, bit 6 `drv_reset` (held while set), bit 5 `iordy_en`, bit 4 `port8_sel`, bit 3 `irq_act_low`, bit 1 `bm_en` and bit 0 `io_en`.
- R5: With pointer bit 7 set, each data read or write strobe advances the index by one, and index 6 (or 7) goes to 0. With bit 7 clear, the index does not change.
- R6: Index 2 (count bits 7-0) and index 3 (read-ahead control) always read 0. `ra_count` is the 10-bit value {index 3 bits 1-0, index 2}. Index 3 bit 7 drives `ra_en` and bit 4 drives `mode4_en`.
- R7: Writing index 3 with bit 6 set gives one `fifo_clr` pulse of one clock, on the selected channel only, in the cycle after the write. Nothing holds it.
- R8: Index 7 reads 0, and a data write at index 7 changes no register.
- R9: Byte registers read with the upper byte 0. General-config bit 2 is not stored and reads 0.
- R10: When a pointer write and a data access fall in the same cycle, the data access uses the old pointer. The pointer takes the written value without advancing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_wr | input | 1 | Pointer write strobe |
| ptr_wdata | input | 8 | Pointer write value |
| ptr_rdata | output | 8 | Pointer read value (bit 5 reads 0) |
| dat_wr | input | 1 | Data write strobe |
| dat_rd | input | 1 | Data read strobe (ends a read access) |
| dat_wdata | input | 16 | Data write value |
| dat_rdata | output | 16 | Data read value of selected register |
| devsel_medium | output | 1 | Medium target response timing |
| burst_en | output | 1 | Master burst enabled |
| posted_wait | output | 1 | One wait state on posted writes |
| cmd_base | output | NCH*16 | Command-block base per channel |
| ctl_base | output | NCH*16 | Control-block base per channel |
| dma_en | output | NCH | DMA enable per channel |
| drv_reset | output | NCH | Drive reset asserted |
| iordy_en | output | NCH | Ready-line sampling enabled |
| port8_sel | output | NCH | 8-bit data port selected |
| irq_act_low | output | NCH | Interrupt active low |
| bm_en | output | NCH | Bus-master mode |
| io_en | output | NCH | I/O decoding enabled |
| ra_en | output | NCH | Read-ahead enabled |
| mode4_en | output | NCH | Fast timing mode enabled |
| fifo_clr | output | NCH | One-clock FIFO clear pulse |
| ra_count | output | NCH*10 | Read-ahead count per channel |
| data_tim | output | NCH*8 | Data-port timing byte per channel |
| cmd_tim | output | NCH*8 | Command-port timing byte per channel |

## Verification
The properties check, on every cycle, the following pointer and bank rules:
- The index wraps from 6 to 0 and holds when no access occurs.
- The burst option follows the inverse of the written bit.
- Write-only and index-7 slots read 0, and index 7 never disturbs a register.
- Every FIFO-clear pulse follows a control write and is never active on two channels at once.

Only the bench scenarios can show the reset contents of each bank and the separation between channels. The same holds for the read-back masks on byte registers and the assembly of the 10-bit count from two registers. The bench also shows the precedence when a pointer write and a data access collide.

// File: rtl/cfg_window_pkg.sv
package cfg_window_pkg;
  localparam int IDX_W   = 3;
  localparam int NUM_IDX = 7;
  localparam int WORD_W  = 16;
  localparam int BYTE_W  = 8;
  localparam int RA_W    = 10;
  localparam int LAST_IDX = NUM_IDX - 1;

  // pointer byte bit positions (software-visible encoding)
  localparam int PB_CH      = 3;
  localparam int PB_DEVSEL  = 4;
  localparam int PB_NOBURST = 5;
  localparam int PB_WAIT    = 6;
  localparam int PB_AUTO    = 7;

  localparam logic [BYTE_W-1:0] PTR_RST    = 8'h50;
  localparam logic [BYTE_W-1:0] PTR_RDMASK = 8'hDF;
  localparam logic [BYTE_W-1:0] GEN_RST    = 8'h01;
  localparam logic [BYTE_W-1:0] GEN_MASK   = 8'hFB;
  localparam logic [BYTE_W-1:0] DTIM_RST   = 8'hF5;
  localparam logic [BYTE_W-1:0] CTIM_RST   = 8'hDE;
  localparam logic [WORD_W-1:0] CH_STRIDE  = 16'h0080;

  typedef enum logic [IDX_W-1:0] {
    IX_CMD_BASE = 3'd0,
    IX_GENERAL  = 3'd1,
    IX_RA_LOW   = 3'd2,
    IX_RA_CTRL  = 3'd3,
    IX_CTL_BASE = 3'd4,
    IX_DAT_TIM  = 3'd5,
    IX_CMD_TIM  = 3'd6,
    IX_UNUSED   = 3'd7
  } cfg_idx_e;

  function automatic logic [WORD_W-1:0] cmd_base_rst(input int ch);
    return 16'h01F0 - CH_STRIDE * WORD_W'(ch);
  endfunction

  function automatic logic [WORD_W-1:0] ctl_base_rst(input int ch);
    return 16'h03F6 - CH_STRIDE * WORD_W'(ch);
  endfunction
endpackage

// File: rtl/cfg_window_ptr.sv
module cfg_window_ptr
  import cfg_window_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_wr,
  input  logic [BYTE_W-1:0] ptr_wdata,
  input  logic              access,
  output logic [BYTE_W-1:0] ptr_q
);
  logic [IDX_W-1:0] idx_next;

  always_comb begin
    if (ptr_q[IDX_W-1:0] >= IDX_W'(LAST_IDX)) idx_next = '0;
    else                                      idx_next = ptr_q[IDX_W-1:0] + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      ptr_q <= PTR_RST;
    else if (ptr_wr)                 ptr_q <= ptr_wdata;
    else if (access && ptr_q[PB_AUTO]) ptr_q[IDX_W-1:0] <= idx_next;
  end
endmodule

// File: rtl/cfg_window_bank.sv
module cfg_window_bank
  import cfg_window_pkg::*;
#(
  parameter int CH = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] cmd_base,
  output logic [WORD_W-1:0] ctl_base,
  output logic [BYTE_W-1:0] gen_cfg,
  output logic [RA_W-1:0]   ra_count,
  output logic              ra_en,
  output logic              mode4_en,
  output logic              fifo_clr,
  output logic [BYTE_W-1:0] data_tim,
  output logic [BYTE_W-1:0] cmd_tim
);
  logic [BYTE_W-1:0]      ra_low_q;
  logic [RA_W-BYTE_W-1:0] ra_high_q;
  cfg_idx_e               sel;

  assign sel      = cfg_idx_e'(idx);
  assign ra_count = {ra_high_q, ra_low_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_base  <= cmd_base_rst(CH);
      ctl_base  <= ctl_base_rst(CH);
      gen_cfg   <= GEN_RST;
      ra_low_q  <= '0;
      ra_high_q <= '0;
      ra_en     <= 1'b0;
      mode4_en  <= 1'b0;
      fifo_clr  <= 1'b0;
      data_tim  <= DTIM_RST;
      cmd_tim   <= CTIM_RST;
    end else begin
      fifo_clr <= wr_en && (sel == IX_RA_CTRL) && wdata[6];
      if (wr_en) begin
        case (sel)
          IX_CMD_BASE: cmd_base <= wdata;
          IX_GENERAL:  gen_cfg  <= wdata[BYTE_W-1:0] & GEN_MASK;
          IX_RA_LOW:   ra_low_q <= wdata[BYTE_W-1:0];
          IX_RA_CTRL: begin
            ra_en     <= wdata[7];
            mode4_en  <= wdata[4];
            ra_high_q <= wdata[RA_W-BYTE_W-1:0];
          end
          IX_CTL_BASE: ctl_base <= wdata;
          IX_DAT_TIM:  data_tim <= wdata[BYTE_W-1:0];
          IX_CMD_TIM:  cmd_tim  <= wdata[BYTE_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (sel)
      IX_CMD_BASE: rdata = cmd_base;
      IX_GENERAL:  rdata = {{(WORD_W-BYTE_W){1'b0}}, gen_cfg};
      IX_CTL_BASE: rdata = ctl_base;
      IX_DAT_TIM:  rdata = {{(WORD_W-BYTE_W){1'b0}}, data_tim};
      IX_CMD_TIM:  rdata = {{(WORD_W-BYTE_W){1'b0}}, cmd_tim};
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/cfg_window.sv
module cfg_window
  import cfg_window_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ptr_wr,
  input  logic [7:0]             ptr_wdata,
  output logic [7:0]             ptr_rdata,
  input  logic                   dat_wr,
  input  logic                   dat_rd,
  input  logic [15:0]            dat_wdata,
  output logic [15:0]            dat_rdata,
  output logic                   devsel_medium,
  output logic                   burst_en,
  output logic                   posted_wait,
  output logic [NCH*16-1:0]      cmd_base,
  output logic [NCH*16-1:0]      ctl_base,
  output logic [NCH-1:0]         dma_en,
  output logic [NCH-1:0]         drv_reset,
  output logic [NCH-1:0]         iordy_en,
  output logic [NCH-1:0]         port8_sel,
  output logic [NCH-1:0]         irq_act_low,
  output logic [NCH-1:0]         bm_en,
  output logic [NCH-1:0]         io_en,
  output logic [NCH-1:0]         ra_en,
  output logic [NCH-1:0]         mode4_en,
  output logic [NCH-1:0]         fifo_clr,
  output logic [NCH*10-1:0]      ra_count,
  output logic [NCH*8-1:0]       data_tim,
  output logic [NCH*8-1:0]       cmd_tim
);
  logic [BYTE_W-1:0] ptr_q;
  logic              ch_sel;
  logic [WORD_W-1:0] bank_rd  [NCH];
  logic [BYTE_W-1:0] bank_gen [NCH];

  cfg_window_ptr u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .ptr_wr    (ptr_wr),
    .ptr_wdata (ptr_wdata),
    .access    (dat_wr | dat_rd),
    .ptr_q     (ptr_q)
  );

  assign ch_sel        = ptr_q[PB_CH];
  assign ptr_rdata     = ptr_q & PTR_RDMASK;
  assign devsel_medium = ptr_q[PB_DEVSEL];
  assign burst_en      = ~ptr_q[PB_NOBURST];
  assign posted_wait   = ptr_q[PB_WAIT];

  for (genvar c = 0; c < NCH; c++) begin : g_bank
    cfg_window_bank #(.CH(c)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (dat_wr && (ch_sel == 1'(c))),
      .idx      (ptr_q[IDX_W-1:0]),
      .wdata    (dat_wdata),
      .rdata    (bank_rd[c]),
      .cmd_base (cmd_base[c*WORD_W +: WORD_W]),
      .ctl_base (ctl_base[c*WORD_W +: WORD_W]),
      .gen_cfg  (bank_gen[c]),
      .ra_count (ra_count[c*RA_W +: RA_W]),
      .ra_en    (ra_en[c]),
      .mode4_en (mode4_en[c]),
      .fifo_clr (fifo_clr[c]),
      .data_tim (data_tim[c*BYTE_W +: BYTE_W]),
      .cmd_tim  (cmd_tim[c*BYTE_W +: BYTE_W])
    );
    assign dma_en[c]      = bank_gen[c][7];
    assign drv_reset[c]   = bank_gen[c][6];
    assign iordy_en[c]    = bank_gen[c][5];
    assign port8_sel[c]   = bank_gen[c][4];
    assign irq_act_low[c] = bank_gen[c][3];
    assign bm_en[c]       = bank_gen[c][1];
    assign io_en[c]       = bank_gen[c][0];
  end

  always_comb begin
    dat_rdata = '0;
    for (int c = 0; c < NCH; c++)
      if (ch_sel == 1'(c)) dat_rdata = bank_rd[c];
  end
endmodule

// File: rtl/cfg_window_chk.sv
module cfg_window_chk #(
  parameter int NCH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ptr_wr,
  input logic [7:0]        ptr_wdata,
  input logic [7:0]        ptr_rdata,
  input logic              dat_wr,
  input logic              dat_rd,
  input logic [15:0]       dat_rdata,
  input logic              burst_en,
  input logic [NCH-1:0]    fifo_clr,
  input logic [NCH*16-1:0] cmd_base,
  input logic [NCH*16-1:0] ctl_base,
  input logic [NCH*8-1:0]  data_tim,
  input logic [NCH*8-1:0]  cmd_tim
);
  assert_burst_opt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr |=> (burst_en == !$past(ptr_wdata[5])));

  assert_index_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_wr && (dat_rd || dat_wr) && ptr_rdata[7] && ptr_rdata[2:0] == 3'd6)
      |=> (ptr_rdata[2:0] == 3'd0));

  assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_wr && !dat_rd && !dat_wr) |=> $stable(ptr_rdata));

  assert_write_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_rdata[2:0] == 3'd2 || ptr_rdata[2:0] == 3'd3) |-> (dat_rdata == 16'h0));

  assert_fifo_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_clr != '0) |-> $past(dat_wr && ptr_rdata[2:0] == 3'd3));

  assert_fifo_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fifo_clr));

  assert_idx7_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_rdata[2:0] == 3'd7) |-> (dat_rdata == 16'h0));

  assert_idx7_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && ptr_rdata[2:0] == 3'd7)
      |=> ($stable(cmd_base) && $stable(ctl_base) && $stable(data_tim) && $stable(cmd_tim)));
endmodule

bind cfg_window cfg_window_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/cfg_window_tb_top.sv
`timescale 1ns/1ps
module cfg_window_tb_top;
  localparam int NCH = 2;
  localparam logic [1:0] OP_WP = 2'd0, OP_WD = 2'd1, OP_RD = 2'd2, OP_RP = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] val;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 37;
  localparam vec_t VECS [NVEC] = '{
    '{OP_RP, 16'h0000, 16'h0050, 4'd1},  // R1 reset pointer
    '{OP_WP, 16'h0080, 16'h0000, 4'd3},  // ch0 idx0, auto
    '{OP_RD, 16'h0000, 16'h01F0, 4'd3},  // R3
    '{OP_RD, 16'h0000, 16'h0001, 4'd3},
    '{OP_RD, 16'h0000, 16'h0000, 4'd6},  // R6 idx2
    '{OP_RD, 16'h0000, 16'h0000, 4'd6},  // R6 idx3
    '{OP_RD, 16'h0000, 16'h03F6, 4'd3},
    '{OP_RD, 16'h0000, 16'h00F5, 4'd3},
    '{OP_RD, 16'h0000, 16'h00DE, 4'd3},
    '{OP_RD, 16'h0000, 16'h01F0, 4'd5},  // R5 wrap 6->0
    '{OP_WP, 16'h0088, 16'h0000, 4'd3},  // ch1 idx0
    '{OP_RD, 16'h0000, 16'h0170, 4'd3},
    '{OP_WP, 16'h008C, 16'h0000, 4'd3},  // ch1 idx4
    '{OP_RD, 16'h0000, 16'h0376, 4'd3},
    '{OP_RD, 16'h0000, 16'h00F5, 4'd3},
    '{OP_RD, 16'h0000, 16'h00DE, 4'd3},
    '{OP_RD, 16'h0000, 16'h0170, 4'd5},  // R5 wrap on ch1
    '{OP_WP, 16'h0080, 16'h0000, 4'd4},
    '{OP_WD, 16'h1234, 16'h0000, 4'd4},  // R4 ch0 idx0
    '{OP_WD, 16'hFFFF, 16'h0000, 4'd4},  // ch0 idx1
    '{OP_WP, 16'h0000, 16'h0000, 4'd5},
    '{OP_RD, 16'h0000, 16'h1234, 4'd4},
    '{OP_RD, 16'h0000, 16'h1234, 4'd5},  // R5 no advance
    '{OP_WP, 16'h0001, 16'h0000, 4'd9},
    '{OP_RD, 16'h0000, 16'h00FB, 4'd9},  // R9 bit2 dropped
    '{OP_WP, 16'h0008, 16'h0000, 4'd4},
    '{OP_RD, 16'h0000, 16'h0170, 4'd4},  // R4 ch1 untouched
    '{OP_WP, 16'h007F, 16'h0000, 4'd2},
    '{OP_RP, 16'h0000, 16'h005F, 4'd2},  // R2 bit5 reads 0
    '{OP_WD, 16'hAAAA, 16'h0000, 4'd8},  // R8 idx7 write
    '{OP_RD, 16'h0000, 16'h0000, 4'd8},
    '{OP_WP, 16'h000D, 16'h0000, 4'd8},
    '{OP_RD, 16'h0000, 16'h00F5, 4'd8},
    '{OP_WP, 16'h0005, 16'h0000, 4'd9},
    '{OP_WD, 16'hAB09, 16'h0000, 4'd9},
    '{OP_RD, 16'h0000, 16'h0009, 4'd9},  // R9 upper byte 0
    '{OP_RP, 16'h0000, 16'h0005, 4'd2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ptr_wr = 1'b0, dat_wr = 1'b0, dat_rd = 1'b0;
  logic [7:0]  ptr_wdata = '0;
  logic [15:0] dat_wdata = '0;
  logic [7:0]  ptr_rdata;
  logic [15:0] dat_rdata;
  logic devsel_medium, burst_en, posted_wait;
  logic [NCH*16-1:0] cmd_base, ctl_base;
  logic [NCH-1:0] dma_en, drv_reset, iordy_en, port8_sel, irq_act_low, bm_en, io_en;
  logic [NCH-1:0] ra_en, mode4_en, fifo_clr;
  logic [NCH*10-1:0] ra_count;
  logic [NCH*8-1:0]  data_tim, cmd_tim;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cfg_window #(.NCH(NCH)) dut_i (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_ptr(input logic [7:0] v);
    @(negedge clk); ptr_wr = 1'b1; ptr_wdata = v;
    @(negedge clk); ptr_wr = 1'b0;
  endtask

  task automatic wr_dat(input logic [15:0] v);
    @(negedge clk); dat_wr = 1'b1; dat_wdata = v;
    @(negedge clk); dat_wr = 1'b0;
  endtask

  task automatic rd_dat(input string req, input logic [15:0] exp);
    @(negedge clk);
    check(req, 32'(dat_rdata), 32'(exp));
    dat_rd = 1'b1;
    @(negedge clk); dat_rd = 1'b0;
  endtask

  task automatic check_reset_state();
    @(negedge clk);
    check("R1 ptr", 32'(ptr_rdata), 32'h50);
    check("R1 opts", {29'd0, devsel_medium, burst_en, posted_wait}, 32'h7);
    check("R3 cmd_base", cmd_base, 32'h0170_01F0);
    check("R3 ctl_base", ctl_base, 32'h0376_03F6);
    check("R3 io/dma", {28'd0, io_en, dma_en}, 32'hC);
    check("R3 timing", {data_tim, cmd_tim}, 32'hF5F5_DEDE);
    check("R7 fifo idle", 32'(fifo_clr), 32'h0);
    check("R6 count", 32'(ra_count), 32'h0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_reset_state();

    for (int i = 0; i < NVEC; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      case (VECS[i].op)
        OP_WP: wr_ptr(VECS[i].val[7:0]);
        OP_WD: wr_dat(VECS[i].val);
        OP_RD: rd_dat(tag, VECS[i].exp);
        default: begin
          @(negedge clk);
          check(tag, 32'(ptr_rdata), 32'(VECS[i].exp));
        end
      endcase
    end

    // R2 global option outputs
    wr_ptr(8'h20);
    check("R2 opts off", {29'd0, devsel_medium, burst_en, posted_wait}, 32'h0);
    wr_ptr(8'h50);
    check("R2 opts on", {29'd0, devsel_medium, burst_en, posted_wait}, 32'h7);

    // R6 / R7 read-ahead and FIFO clear
    wr_ptr(8'h02);
    wr_dat(16'h0034);
    wr_ptr(8'h03);
    @(negedge clk); dat_wr = 1'b1; dat_wdata = 16'h00D3;
    @(negedge clk); dat_wr = 1'b0;
    check("R7 fifo pulse", 32'(fifo_clr), 32'h1);
    @(negedge clk);
    check("R7 fifo self-clear", 32'(fifo_clr), 32'h0);
    check("R6 count", 32'(ra_count), 32'h0000_0334);
    check("R6 ra_en/mode4", {28'd0, ra_en, mode4_en}, 32'h5);
    rd_dat("R6 ctrl readback", 16'h0000);

    // R4 general config decode on ch1, ch0 keeps 0xFB
    wr_ptr(8'h09);
    wr_dat(16'h0080);
    check("R4 dma_en", 32'(dma_en), 32'h3);
    check("R4 io_en", 32'(io_en), 32'h1);
    check("R4 drv_reset", 32'(drv_reset), 32'h1);
    check("R4 misc ch0", {27'd0, iordy_en[0], port8_sel[0], irq_act_low[0], bm_en[0], 1'b0}, 32'h1E);

    // R10 pointer write colliding with data write
    wr_ptr(8'h80);
    @(negedge clk);
    ptr_wr = 1'b1; ptr_wdata = 8'h84; dat_wr = 1'b1; dat_wdata = 16'h5555;
    @(negedge clk);
    ptr_wr = 1'b0; dat_wr = 1'b0;
    check("R10 ptr wins", 32'(ptr_rdata), 32'h84);
    wr_ptr(8'h00);
    rd_dat("R10 data used old ptr", 16'h5555);

    // R1 / R3 reset again
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check_reset_state();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule